// File: doc/BRIEF.md
# Supervisory Reset Generator

This block drives one active-low system reset from a set of rail undervoltage flags and a manual-reset request. Reset goes low when any rail flag reports a rail under its threshold, or when the manual-reset input has been held low long enough to pass a minimum-width filter. Once every cause has cleared, reset stays low for a timeout and then releases. A new cause during that timeout pulls the count back to zero.

The manual-reset and margin inputs are asynchronous pins. They pass through a two-flop synchronizer before any logic uses them. The rail flags come from comparator logic that is already synchronous to the clock, so they are used as they arrive. While margin is held low, the reset output and the timeout count are frozen. Margin therefore wins over a manual reset that arrives at the same time. A select input chooses the timeout length: either a built-in default count or a count supplied on a port.

All lengths are expressed in clock cycles. With the default parameters and a 200 MHz clock, the default timeout is 200 ms and the manual-reset filter needs 1 µs of low level.

Top module: `sup_reset_gen`

## Requirements
- R1: A rail flag bit of 1 means that rail is under threshold. When any such bit is 1 and margin is inactive, `sys_rst_n_o` is 0 after the next clock edge.
- R2: After synchronization, `mr_n_i` must read low on MR_MIN_CYC consecutive clocks to count as a cause. Reset then goes low MR_MIN_CYC+3 clock edges after the input falls. A low pulse one cycle shorter than that width has no effect on `sys_rst_n_o`.
- R3: `sys_rst_n_o` returns to 1 exactly L clock edges after the last edge at which a cause was seen, where L is the selected timeout. For a manual reset this is L+3 edges after `mr_n_i` rises.
- R4: During `rst`, `sys_rst_n_o` is 0. After `rst` is released, with no cause present, it rises exactly L edges later.
- R5: While the synchronized margin input is low (`margin_n_i` = 0), `sys_rst_n_o` and the timeout count hold their values. Counting resumes from the frozen value two edges after margin returns high.
- R6: Margin has priority over manual reset: a manual-reset hold of any length that lies inside a margin-low window never asserts reset.
- R7: With `tmo_sel_i` = 0, L = DEF_TMO_CYC. With `tmo_sel_i` = 1, L = `tmo_prog_i`, and a programmed value of 0 acts as 1.
- R8: A cause that appears while the timeout is running re-asserts the hold and restarts the count from zero.
- R9: With `mr_n_i` idle high and all rail flags 0, `sys_rst_n_o` stays 1 after its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rail_low_i | input | NUM_RAILS | Synchronous undervoltage flags, 1 = rail under threshold |
| mr_n_i | input | 1 | Asynchronous active-low manual-reset request, idles high |
| margin_n_i | input | 1 | Asynchronous active-low freeze of the reset output |
| tmo_sel_i | input | 1 | Timeout source: 0 = default count, 1 = programmed count |
| tmo_prog_i | input | TMO_W | Programmed timeout in clock cycles |
| sys_rst_n_o | output | 1 | Registered active-low system reset |

## Verification
A faulty width counter in the manual-reset filter shows up at the reset pin: the reset edge lands one cycle early or late against the MR_MIN_CYC+3 latency, or a pulse one cycle short of the minimum width gets through. A faulty timeout counter or limit selection changes the release edge, so the bench measures release to the exact cycle for the default count, for a programmed count, for a programmed zero and after a restart. A freeze that leaks shows either as a release during a margin window or as a release count, after the window, that differs from the remaining count computed before the freeze.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {
    TMO_DEFAULT = 1'b0,
    TMO_PROG    = 1'b1
  } tmo_src_e;
endpackage

// File: rtl/sup_sync2.sv
// Two-flop synchronizer for a vector of asynchronous level inputs.
module sup_sync2 #(
  parameter int          WIDTH   = 2,
  parameter logic [31:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= RST_VAL[WIDTH-1:0];
      stage2_q <= RST_VAL[WIDTH-1:0];
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/sup_mr_filter.sv
// Minimum-width qualifier for the synchronized manual-reset level.
module sup_mr_filter #(
  parameter int MR_MIN_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic mr_n_s_i,
  output logic mr_act_o
);
  localparam int MR_W = $clog2(MR_MIN_CYC + 1);
  localparam logic [MR_W-1:0] LAST = MR_W'(MR_MIN_CYC - 1);

  logic [MR_W-1:0] low_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q <= '0;
      mr_act_o  <= 1'b0;
    end else if (mr_n_s_i) begin
      low_cnt_q <= '0;
      mr_act_o  <= 1'b0;
    end else begin
      if (low_cnt_q < LAST) low_cnt_q <= low_cnt_q + 1'b1;
      mr_act_o <= (low_cnt_q >= LAST);
    end
  end

  // R2: any high sample drops the qualified request on the next edge
  p_high_clears_r2 : assert property (@(posedge clk) disable iff (rst)
    mr_n_s_i |=> !mr_act_o);
  // R2: the request can only start after a low sample
  p_rise_after_low_r2 : assert property (@(posedge clk) disable iff (rst)
    $rose(mr_act_o) |-> !$past(mr_n_s_i));
endmodule

// File: rtl/sup_tmo_timer.sv
// Reset hold register and timeout counter with freeze.
module sup_tmo_timer #(
  parameter int TMO_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cause_i,
  input  logic             freeze_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             rst_n_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             done;

  assign done = (cnt_q >= limit_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_o <= 1'b0;
      cnt_q   <= '0;
    end else if (!freeze_i) begin
      if (cause_i) begin
        rst_n_o <= 1'b0;
        cnt_q   <= '0;
      end else if (!rst_n_o) begin
        if (done) begin
          rst_n_o <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R1: an unfrozen cause holds reset low on the next edge
  p_cause_asserts_r1 : assert property (@(posedge clk) disable iff (rst)
    (cause_i && !freeze_i) |=> !rst_n_o);
  // R5: a frozen cycle leaves the output unchanged
  p_freeze_holds_r5 : assert property (@(posedge clk) disable iff (rst)
    freeze_i |=> $stable(rst_n_o));
  // R3: release only follows an unfrozen cycle with no cause
  p_clean_release_r3 : assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> ($past(!cause_i) && $past(!freeze_i)));
  // R4: the first cycle after power-on reset shows reset asserted
  p_por_low_r4 : assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rst_n_o);
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import sup_pkg::*;
#(
  parameter int NUM_RAILS   = 4,
  parameter int MR_MIN_CYC  = 200,
  parameter int DEF_TMO_CYC = 40_000_000,
  parameter int TMO_W       = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RAILS-1:0] rail_low_i,
  input  logic                 mr_n_i,
  input  logic                 margin_n_i,
  input  logic                 tmo_sel_i,
  input  logic [TMO_W-1:0]     tmo_prog_i,
  output logic                 sys_rst_n_o
);
  localparam int SYNC_W = 2;
  localparam logic [TMO_W-1:0] DEF_LIM = TMO_W'(DEF_TMO_CYC);
  localparam logic [TMO_W-1:0] ONE_LIM = TMO_W'(1);

  logic [SYNC_W-1:0] async_in;
  logic [SYNC_W-1:0] sync_out;
  logic              mr_n_s;
  logic              margin_n_s;
  logic              mr_act;
  logic              cause;
  logic [TMO_W-1:0]  limit;
  tmo_src_e          src;

  assign async_in = {margin_n_i, mr_n_i};

  sup_sync2 #(.WIDTH(SYNC_W), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (async_in),
    .q_o (sync_out)
  );

  assign mr_n_s     = sync_out[0];
  assign margin_n_s = sync_out[1];

  sup_mr_filter #(.MR_MIN_CYC(MR_MIN_CYC)) u_mr_filter (
    .clk      (clk),
    .rst      (rst),
    .mr_n_s_i (mr_n_s),
    .mr_act_o (mr_act)
  );

  assign cause = (|rail_low_i) | mr_act;
  assign src   = tmo_src_e'(tmo_sel_i);

  always_comb begin
    if (src == TMO_PROG) limit = (tmo_prog_i == '0) ? ONE_LIM : tmo_prog_i;
    else                 limit = DEF_LIM;
  end

  sup_tmo_timer #(.TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .cause_i  (cause),
    .freeze_i (!margin_n_s),
    .limit_i  (limit),
    .rst_n_o  (sys_rst_n_o)
  );

  // R6: a qualified manual reset inside a margin window leaves the output alone
  p_margin_over_mr_r6 : assert property (@(posedge clk) disable iff (rst)
    (!margin_n_s && mr_act) |=> $stable(sys_rst_n_o));
endmodule

// File: tb/sup_reset_gen_tb.sv
module sup_reset_gen_tb;
  localparam int NR  = 3;
  localparam int M   = 20;
  localparam int L   = 100;
  localparam int TW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NR-1:0] rail_low = '0;
  logic          mr_n = 1'b1;
  logic          margin_n = 1'b1;
  logic          tmo_sel = 1'b0;
  logic [TW-1:0] tmo_prog = '0;
  logic          rst_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sup_reset_gen #(.NUM_RAILS(NR), .MR_MIN_CYC(M), .DEF_TMO_CYC(L), .TMO_W(TW)) u_dut (
    .clk(clk), .rst(rst), .rail_low_i(rail_low), .mr_n_i(mr_n),
    .margin_n_i(margin_n), .tmo_sel_i(tmo_sel), .tmo_prog_i(tmo_prog),
    .sys_rst_n_o(rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  // posedges until rst_n reads 1, sampled at negedges
  task automatic edges_to_high(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!rst_n && n < 1000);
  endtask

  task automatic edges_to_low(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (rst_n && n < 1000);
  endtask

  task automatic stays(input int n, input logic v, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (rst_n !== v) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_power_on();
    int n;
    chk(rst_n === 1'b0, "R4 low in reset", rst_n, 0);
    rst = 1'b0;
    edges_to_high(n);
    chk(n == L, "R4 first release", n, L);
    stays(50, 1'b1, "R9 idle stays high");
  endtask

  task automatic t_rails();
    int n;
    rail_low = 3'b010;
    cyc(1);
    chk(rst_n === 1'b0, "R1 rail1 asserts next edge", rst_n, 0);
    cyc(4);
    rail_low = '0;
    edges_to_high(n);
    chk(n == L, "R3 release after rail", n, L);
    rail_low = 3'b101;
    cyc(1);
    chk(rst_n === 1'b0, "R1 rails0,2 assert", rst_n, 0);
    rail_low = 3'b100;
    stays(L + 10, 1'b0, "R1 one rail still low holds");
    rail_low = '0;
    edges_to_high(n);
    chk(n == L, "R3 release after last rail", n, L);
  endtask

  task automatic t_mr();
    int n;
    mr_n = 1'b0; cyc(M - 1); mr_n = 1'b1;
    stays(40, 1'b1, "R2 short pulse rejected");
    mr_n = 1'b0;
    edges_to_low(n);
    chk(n == M + 3, "R2 assert latency", n, M + 3);
    cyc(M + 3 - n + 5);
    mr_n = 1'b1;
    edges_to_high(n);
    chk(n == L + 3, "R3 release after mr", n, L + 3);
    mr_n = 1'b0; cyc(M); mr_n = 1'b1;
    cyc(3);
    chk(rst_n === 1'b0, "R2 exact width accepted", rst_n, 0);
    edges_to_high(n);
  endtask

  task automatic t_restart();
    int n;
    rail_low = 3'b001; cyc(1); rail_low = '0;
    cyc(50);
    chk(rst_n === 1'b0, "R8 mid timeout low", rst_n, 0);
    rail_low = 3'b100; cyc(1); rail_low = '0;
    edges_to_high(n);
    chk(n == L, "R8 restart from zero", n, L);
  endtask

  task automatic t_select();
    int n;
    tmo_sel = 1'b1; tmo_prog = 12'd37;
    rail_low = 3'b001; cyc(1); rail_low = '0;
    edges_to_high(n);
    chk(n == 37, "R7 programmed count", n, 37);
    tmo_prog = '0;
    rail_low = 3'b001; cyc(1); rail_low = '0;
    edges_to_high(n);
    chk(n == 1, "R7 zero acts as one", n, 1);
    tmo_sel = 1'b0; tmo_prog = 12'd37;
    rail_low = 3'b001; cyc(1); rail_low = '0;
    edges_to_high(n);
    chk(n == L, "R7 default count", n, L);
  endtask

  task automatic t_margin();
    int n;
    margin_n = 1'b0; cyc(4);
    rail_low = 3'b010;
    stays(10, 1'b1, "R5 frozen high under rail");
    rail_low = '0; cyc(3);
    margin_n = 1'b1;
    stays(20, 1'b1, "R5 high after margin");
    rail_low = 3'b001; cyc(1); rail_low = '0;
    cyc(10);
    margin_n = 1'b0;
    stays(200, 1'b0, "R5 frozen low past timeout");
    margin_n = 1'b1;
    edges_to_high(n);
    chk(n == 90, "R5 resume from frozen count", n, 90);
  endtask

  task automatic t_priority();
    margin_n = 1'b0; mr_n = 1'b0;
    stays(60, 1'b1, "R6 margin beats mr");
    mr_n = 1'b1; cyc(5);
    margin_n = 1'b1;
    stays(30, 1'b1, "R6 no reset after window");
  endtask

  initial begin
    cyc(3);
    t_power_on();
    t_rails();
    t_mr();
    t_restart();
    t_select();
    t_margin();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule